// File: doc/BRIEF.md
# Low-Power Mode State Controller

This block is the device-level power-state sequencer. It holds the chip in one of six states: normal run, sleep, stop, oscillation-stabilization wait, setting-initialization reset and operation-initialization reset. From those states it derives the gating enables for the CPU clock, the peripheral clocks, the PLL and the three oscillators, plus the control that floats the external pins. Software moves the chip into sleep or stop through request inputs. Interrupt sources wake it again. Two active-low reset pins and a software reset strobe force the reset states from anywhere.

Leaving stop always passes through a timed stabilization state. In that state the oscillators and the selected PLL run while every internal clock stays gated. The pin float is released as soon as that state is entered. The length of the wait is a live input that software configures. A setting-initialization reset runs the same stabilization wait and then continues through the operation reset before the chip runs again. Power-on (`rst_n`) places the block in the setting-initialization state, so the first run always follows that full sequence.

Top module: `lpm_state_ctrl`

## Requirements
- R1: The state code is 0 in run. In run, `cpu_clk_en` and `per_clk_en` are 1, `pll_en` equals `pll_on`, all three oscillator enables are 1 and `pin_hiz` is 0.
- R2: In run, `sleep_req` moves the block to sleep (code 1) at the next clock edge. In sleep, `cpu_clk_en` is 0, `per_clk_en` is 1, `pll_en` equals `pll_on`, the oscillators are on and `pin_hiz` is 0. Sleep is entered only from run.
- R3: Sleep returns to run at the next edge when any bit of `irq_vec` is 1 while the same bit of `irq_mask` is 1. Pending bits whose mask bit is 0 leave the block in sleep.
- R4: In run, `stop_req` moves the block to stop (code 2) at the next edge. When `sleep_req` and `stop_req` are both asserted, stop wins. In stop, the CPU clock, the peripheral clocks and the PLL are all off.
- R5: In stop, `main_osc_en`, `sub_osc_en` and `rc_osc_en` equal `keep_main`, `keep_sub` and `keep_rc`. In every other state they are 1.
- R6: In stop, `pin_hiz` equals `hiz_en`. In all other states `pin_hiz` is 0.
- R7: Stop is left at the next edge only when some bit of `stop_wake_vec` is 1, and it then goes to the stabilization state (code 3). `irq_vec` has no effect in stop.
- R8: In the stabilization state, the CPU and peripheral clocks are off, `pll_en` equals `pll_on`, the oscillators are on and `pin_hiz` is 0. The state lasts exactly `wait_cnt`+1 cycles. Its counter restarts on every entry. After the wait it moves to run when it was entered from stop.
- R9: `init_pin_n` is low-active and passes through SYNC_STAGES flip-flops. From any state, the block is in setting-initialization (code 4) SYNC_STAGES+1 edges after the pin falls. This has priority over the operation reset and over all wake events. In setting-initialization, the CPU clock, the peripheral clocks and the PLL are off.
- R10: From any state, an operation reset moves the block to code 5 when setting-initialization is not requested. The operation reset comes from `oprst_pin_n` (low-active, synchronized the same way, SYNC_STAGES+1 edges) or from `sw_rst` (next edge). This has priority over wake events and requests. In code 5, the CPU clock, the peripheral clocks and the PLL are off.
- R11: Setting-initialization holds while its pin is low. After release it enters the stabilization state. After the wait it moves to the operation-reset state and then to run.
- R12: The operation-reset state holds while the synchronized `oprst_pin_n` is low. A `sw_rst` strobe alone gives one cycle of it. The following edge returns the block to run.
- R13: While `rst_n` is low, the block is in setting-initialization (code 4) and both pin synchronizers read as asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Power-on reset, low-active, asynchronous |
| sleep_req | input | 1 | Software request to enter sleep |
| stop_req | input | 1 | Software request to enter stop |
| irq_vec | input | NUM_IRQ | Pending interrupt requests |
| irq_mask | input | NUM_IRQ | Per-interrupt enable for sleep wake |
| stop_wake_vec | input | NUM_STOP_WAKE | Clockless and stabilization-timer wake sources for stop |
| init_pin_n | input | 1 | Setting-initialization reset pin, low-active, asynchronous |
| oprst_pin_n | input | 1 | Operation-initialization reset pin, low-active, asynchronous |
| sw_rst | input | 1 | Software operation-reset strobe |
| wait_cnt | input | WAIT_W | Stabilization wait length minus one, in cycles |
| pll_on | input | 1 | PLL selected for use |
| hiz_en | input | 1 | Float external pins during stop |
| keep_main | input | 1 | Keep main oscillator running in stop |
| keep_sub | input | 1 | Keep sub oscillator running in stop |
| keep_rc | input | 1 | Keep RC oscillator running in stop |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| pll_en | output | 1 | PLL enable |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| pin_hiz | output | 1 | External pin high-impedance control |
| state_code | output | 3 | Current state (0 run, 1 sleep, 2 stop, 3 stabilization wait, 4 setting-init, 5 operation reset) |

## Verification
The assertions assume that `wait_cnt` does not change while the block is in the stabilization state. The bound on that state's length is measured against the value that is live during the wait. The assertions also assume that the power-on reset is asserted from time zero. The bench changes `wait_cnt` only while the block is in run. It drives every input at the falling clock edge and holds `rst_n` low over the first cycles. Every reset pin transition is held for several cycles, so the synchronizers always pass a clean level.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_SLEEP = 3'd1,
      ST_STOP  = 3'd2,
      ST_OSW   = 3'd3,
      ST_INIT  = 3'd4,
      ST_RST   = 3'd5
   } lpm_state_e;

   typedef struct packed {
      logic cpu;
      logic per;
      logic pll;
      logic mosc;
      logic sosc;
      logic rosc;
      logic hiz;
   } lpm_gate_t;

endpackage

// File: rtl/lpm_pin_sync.sv
// Multi-stage synchronizer for a low-active asynchronous pin.
// Flops reset to 0 so the pin reads as asserted during power-on.
module lpm_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic active
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin_n};
   end

   assign active = ~chain_q[STAGES-1];

endmodule

// File: rtl/lpm_stab_timer.sv
// Stabilization wait counter: cleared while idle, counts while active,
// flags done when the count equals the configured limit.
module lpm_stab_timer #(
   parameter int WAIT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [WAIT_W-1:0] limit,
   output logic              done
);

   logic [WAIT_W-1:0] cnt_q;

   assign done = active && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!active) cnt_q <= '0;
      else if (!done)   cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/lpm_gate_decode.sv
// Maps the current power state and the stop options to the gate enables.
module lpm_gate_decode
   import lpm_pkg::*;
(
   input  lpm_state_e state,
   input  logic       pll_on,
   input  logic       hiz_en,
   input  logic       keep_main,
   input  logic       keep_sub,
   input  logic       keep_rc,
   output lpm_gate_t  gate
);

   always_comb begin
      gate = '{cpu: 1'b0, per: 1'b0, pll: 1'b0, mosc: 1'b1,
               sosc: 1'b1, rosc: 1'b1, hiz: 1'b0};
      case (state)
         ST_RUN: begin
            gate.cpu = 1'b1;
            gate.per = 1'b1;
            gate.pll = pll_on;
         end
         ST_SLEEP: begin
            gate.per = 1'b1;
            gate.pll = pll_on;
         end
         ST_STOP: begin
            gate.mosc = keep_main;
            gate.sosc = keep_sub;
            gate.rosc = keep_rc;
            gate.hiz  = hiz_en;
         end
         ST_OSW: begin
            gate.pll = pll_on;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lpm_state_ctrl.sv
module lpm_state_ctrl
   import lpm_pkg::*;
#(
   parameter int NUM_IRQ       = 8,
   parameter int NUM_STOP_WAKE = 3,
   parameter int WAIT_W        = 16,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep_req,
   input  logic                     stop_req,
   input  logic [NUM_IRQ-1:0]       irq_vec,
   input  logic [NUM_IRQ-1:0]       irq_mask,
   input  logic [NUM_STOP_WAKE-1:0] stop_wake_vec,
   input  logic                     init_pin_n,
   input  logic                     oprst_pin_n,
   input  logic                     sw_rst,
   input  logic [WAIT_W-1:0]        wait_cnt,
   input  logic                     pll_on,
   input  logic                     hiz_en,
   input  logic                     keep_main,
   input  logic                     keep_sub,
   input  logic                     keep_rc,
   output logic                     cpu_clk_en,
   output logic                     per_clk_en,
   output logic                     pll_en,
   output logic                     main_osc_en,
   output logic                     sub_osc_en,
   output logic                     rc_osc_en,
   output logic                     pin_hiz,
   output logic [2:0]               state_code
);

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lpm_state_ctrl: SYNC_STAGES must be at least 2");
   end
   if (WAIT_W < 1 || WAIT_W > 31) begin : g_bad_wait
      $error("lpm_state_ctrl: WAIT_W must be within 1..31");
   end
   if (NUM_IRQ < 1 || NUM_STOP_WAKE < 1) begin : g_bad_wake
      $error("lpm_state_ctrl: wake vectors need at least one bit");
   end

   lpm_state_e st_q, st_nx;
   logic       from_init_q, from_init_nx;
   logic       init_req, oprst_req, stab_done;
   logic       sleep_wake, stop_wake;
   lpm_gate_t  gate;

   lpm_pin_sync #(.STAGES(SYNC_STAGES)) u_init_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (init_pin_n),
      .active (init_req)
   );

   lpm_pin_sync #(.STAGES(SYNC_STAGES)) u_oprst_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (oprst_pin_n),
      .active (oprst_req)
   );

   lpm_stab_timer #(.WAIT_W(WAIT_W)) u_stab (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (st_q == ST_OSW),
      .limit  (wait_cnt),
      .done   (stab_done)
   );

   assign sleep_wake = |(irq_vec & irq_mask);
   assign stop_wake  = |stop_wake_vec;

   // Next state: setting-init over operation reset over everything else
   always_comb begin
      st_nx        = st_q;
      from_init_nx = from_init_q;
      if (init_req) begin
         st_nx = ST_INIT;
      end else if (oprst_req || sw_rst) begin
         st_nx = ST_RST;
      end else begin
         case (st_q)
            ST_RUN: begin
               if (stop_req)       st_nx = ST_STOP;
               else if (sleep_req) st_nx = ST_SLEEP;
            end
            ST_SLEEP: begin
               if (sleep_wake) st_nx = ST_RUN;
            end
            ST_STOP: begin
               if (stop_wake) begin
                  st_nx        = ST_OSW;
                  from_init_nx = 1'b0;
               end
            end
            ST_OSW: begin
               if (stab_done) st_nx = from_init_q ? ST_RST : ST_RUN;
            end
            ST_INIT: begin
               st_nx        = ST_OSW;
               from_init_nx = 1'b1;
            end
            ST_RST:  st_nx = ST_RUN;
            default: st_nx = ST_INIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_INIT;
         from_init_q <= 1'b1;
      end else begin
         st_q        <= st_nx;
         from_init_q <= from_init_nx;
      end
   end

   lpm_gate_decode u_dec (
      .state     (st_q),
      .pll_on    (pll_on),
      .hiz_en    (hiz_en),
      .keep_main (keep_main),
      .keep_sub  (keep_sub),
      .keep_rc   (keep_rc),
      .gate      (gate)
   );

   assign cpu_clk_en  = gate.cpu;
   assign per_clk_en  = gate.per;
   assign pll_en      = gate.pll;
   assign main_osc_en = gate.mosc;
   assign sub_osc_en  = gate.sosc;
   assign rc_osc_en   = gate.rosc;
   assign pin_hiz     = gate.hiz;
   assign state_code  = st_q;

endmodule

// File: rtl/lpm_state_ctrl_chk.sv
module lpm_state_ctrl_chk
   import lpm_pkg::*;
#(
   parameter int WAIT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        state_code,
   input logic              cpu_clk_en,
   input logic              per_clk_en,
   input logic              pll_en,
   input logic              pin_hiz,
   input logic [WAIT_W-1:0] wait_cnt
);

   // Length of the current stabilization visit so far
   logic [WAIT_W:0] osw_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      osw_len_q <= '0;
      else if (state_code == ST_OSW)   osw_len_q <= osw_len_q + 1'b1;
      else                             osw_len_q <= '0;
   end

   p_run_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == ST_RUN) |-> (cpu_clk_en && per_clk_en));

   p_sleep_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == ST_SLEEP) |-> (!cpu_clk_en && per_clk_en));

   p_sleep_from_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == ST_SLEEP && $past(state_code) != ST_SLEEP)
      |-> ($past(state_code) == ST_RUN));

   p_stop_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == ST_STOP) |-> (!cpu_clk_en && !per_clk_en && !pll_en));

   p_hiz_only_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_hiz |-> (state_code == ST_STOP));

   p_stop_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_code) == ST_STOP && state_code != ST_STOP)
      |-> (state_code == ST_OSW || state_code == ST_INIT || state_code == ST_RST));

   p_osw_min_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == ST_OSW && osw_len_q < {1'b0, wait_cnt})
      |=> (state_code != ST_RUN));

   p_init_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == ST_INIT) |-> (!cpu_clk_en && !per_clk_en && !pll_en));

   p_rst_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_code) == ST_RST && state_code != ST_RST)
      |-> (state_code == ST_RUN || state_code == ST_INIT));

endmodule

bind lpm_state_ctrl lpm_state_ctrl_chk #(.WAIT_W(WAIT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .state_code (state_code),
   .cpu_clk_en (cpu_clk_en),
   .per_clk_en (per_clk_en),
   .pll_en     (pll_en),
   .pin_hiz    (pin_hiz),
   .wait_cnt   (wait_cnt)
);

// File: tb/lpm_state_ctrl_bench.sv
module lpm_state_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NI = 8;
   localparam int NS = 3;
   localparam int WW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          sleep_req, stop_req;
   logic [NI-1:0] irq_vec, irq_mask;
   logic [NS-1:0] stop_wake_vec;
   logic          init_pin_n, oprst_pin_n, sw_rst;
   logic [WW-1:0] wait_cnt;
   logic          pll_on, hiz_en, keep_main, keep_sub, keep_rc;
   logic          cpu_clk_en, per_clk_en, pll_en;
   logic          main_osc_en, sub_osc_en, rc_osc_en, pin_hiz;
   logic [2:0]    state_code;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpm_state_ctrl #(
      .NUM_IRQ(NI), .NUM_STOP_WAKE(NS), .WAIT_W(WW), .SYNC_STAGES(2)
   ) u_lpm_state_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stop_req(stop_req),
      .irq_vec(irq_vec), .irq_mask(irq_mask), .stop_wake_vec(stop_wake_vec),
      .init_pin_n(init_pin_n), .oprst_pin_n(oprst_pin_n), .sw_rst(sw_rst),
      .wait_cnt(wait_cnt), .pll_on(pll_on), .hiz_en(hiz_en),
      .keep_main(keep_main), .keep_sub(keep_sub), .keep_rc(keep_rc),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pll_en(pll_en),
      .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .rc_osc_en(rc_osc_en),
      .pin_hiz(pin_hiz), .state_code(state_code)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // {cpu, per, pll, main, sub, rc, hiz}
   task automatic check_gates(string req, logic [6:0] exp);
      check(req, "gates", int'({cpu_clk_en, per_clk_en, pll_en, main_osc_en,
                                sub_osc_en, rc_osc_en, pin_hiz}), int'(exp));
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // Called at a negedge showing the wait state; returns its length
   task automatic count_osw(output int len);
      len = 0;
      while (state_code == 3'd3 && len < 1000) begin
         len++;
         @(negedge clk);
      end
   endtask

   task automatic enter_stop(input int wake_bit);
      stop_req = 1'b1; cyc(1); stop_req = 1'b0;
      stop_wake_vec = NS'(1 << wake_bit); cyc(1); stop_wake_vec = '0;
   endtask

   task automatic t_power_up();
      int k;
      rst_n = 1'b0;
      cyc(3);
      check("R13", "state in reset", state_code, 4);
      check_gates("R13", 7'b0001110);
      rst_n = 1'b1;
      k = 0;
      while (state_code != 3'd0 && k < 200) begin k++; cyc(1); end
      check("R11", "power-up reaches run", state_code, 0);
      check_gates("R1", 7'b1111110);
   endtask

   task automatic t_sleep();
      sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
      check("R2", "sleep entered", state_code, 1);
      check_gates("R2", 7'b0111110);
      irq_vec = 8'h04; irq_mask = 8'hFB; cyc(1);
      check("R3", "masked irq ignored", state_code, 1);
      irq_mask = 8'hFF; cyc(1);
      check("R3", "enabled irq wakes", state_code, 0);
      irq_vec = '0;
   endtask

   task automatic t_stop_hiz();
      int len;
      wait_cnt = 8'd5; pll_on = 1'b1; hiz_en = 1'b1;
      keep_main = 1'b1; keep_sub = 1'b0; keep_rc = 1'b1;
      sleep_req = 1'b1; stop_req = 1'b1; cyc(1);
      sleep_req = 1'b0; stop_req = 1'b0;
      check("R4", "stop wins over sleep", state_code, 2);
      check_gates("R5", 7'b0001011);
      irq_vec = 8'hFF; irq_mask = 8'hFF; cyc(2);
      check("R7", "irq ignored in stop", state_code, 2);
      check("R6", "pins floated", pin_hiz, 1);
      irq_vec = '0;
      stop_wake_vec = 3'b010; cyc(1); stop_wake_vec = '0;
      check("R7", "wake to stabilization", state_code, 3);
      check_gates("R8", 7'b0011110);
      count_osw(len);
      check("R8", "wait length", len, 6);
      check("R8", "stop path returns to run", state_code, 0);
   endtask

   task automatic t_stop_nohiz();
      int len;
      wait_cnt = 8'd0; hiz_en = 1'b0;
      keep_main = 1'b0; keep_sub = 1'b1; keep_rc = 1'b0;
      stop_req = 1'b1; cyc(1); stop_req = 1'b0;
      check_gates("R5", 7'b0000100);
      check("R6", "no float when disabled", pin_hiz, 0);
      stop_wake_vec = 3'b100; cyc(1); stop_wake_vec = '0;
      count_osw(len);
      check("R8", "zero wait restarts", len, 1);
      check("R8", "back to run", state_code, 0);
      keep_main = 1'b1; keep_sub = 1'b1; keep_rc = 1'b1;
   endtask

   task automatic t_init();
      int len;
      wait_cnt = 8'd3;
      init_pin_n = 1'b0; cyc(2);
      check("R9", "sync latency", state_code, 0);
      cyc(1);
      check("R9", "init entered", state_code, 4);
      check_gates("R9", 7'b0001110);
      cyc(4);
      check("R11", "init held", state_code, 4);
      init_pin_n = 1'b1; cyc(3);
      check("R11", "init to stabilization", state_code, 3);
      count_osw(len);
      check("R11", "init wait length", len, 4);
      check("R11", "then operation reset", state_code, 5);
      cyc(1);
      check("R12", "reset returns to run", state_code, 0);
   endtask

   task automatic t_prio_from_sleep();
      sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
      init_pin_n = 1'b0; oprst_pin_n = 1'b0; cyc(3);
      check("R9", "init over op reset", state_code, 4);
      init_pin_n = 1'b1; cyc(3);
      check("R10", "op reset after init release", state_code, 5);
      check_gates("R10", 7'b0001110);
      irq_vec = 8'h01; irq_mask = 8'h01; cyc(3);
      check("R12", "op reset held", state_code, 5);
      irq_vec = '0;
      oprst_pin_n = 1'b1; cyc(2);
      check("R12", "still held in sync", state_code, 5);
      cyc(1);
      check("R12", "release to run", state_code, 0);
   endtask

   task automatic t_swrst_from_stop();
      stop_req = 1'b1; cyc(1); stop_req = 1'b0;
      sw_rst = 1'b1; stop_wake_vec = 3'b001; cyc(1);
      sw_rst = 1'b0; stop_wake_vec = '0;
      check("R10", "sw reset over wake", state_code, 5);
      cyc(1);
      check("R12", "strobe gives one cycle", state_code, 0);
   endtask

   task automatic t_oprst_from_osw();
      wait_cnt = 8'd40;
      enter_stop(0);
      check("R7", "in stabilization", state_code, 3);
      oprst_pin_n = 1'b0; cyc(3);
      check("R10", "op reset from stabilization", state_code, 5);
      cyc(2);
      oprst_pin_n = 1'b1; cyc(3);
      check("R12", "run after op reset", state_code, 0);
      check_gates("R1", 7'b1111110);
   endtask

   initial begin
      rst_n = 1'b0; sleep_req = 1'b0; stop_req = 1'b0;
      irq_vec = '0; irq_mask = '0; stop_wake_vec = '0;
      init_pin_n = 1'b1; oprst_pin_n = 1'b1; sw_rst = 1'b0;
      wait_cnt = 8'd2; pll_on = 1'b1; hiz_en = 1'b0;
      keep_main = 1'b1; keep_sub = 1'b1; keep_rc = 1'b1;
      cyc(1);
      t_power_up();
      t_sleep();
      t_stop_hiz();
      t_stop_nohiz();
      t_init();
      t_prio_from_sleep();
      t_swrst_from_stop();
      t_oprst_from_osw();
      cyc(2);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule